// File: doc/BRIEF.md
# Multi-Word Gearbox FIFO

This block is a circular word buffer whose two sides move different numbers of words per access. A write takes `WR_LANES` words from a wide input bus in one clock and places them in consecutive slots. A read returns `RD_LANES` consecutive words on a wide output bus. The read and write pointers step by those lane counts and wrap around the power-of-two depth. A separate occupancy counter tracks how many words are held. It is the usual way to join a datapath that produces several words per beat to one that consumes a different number per beat, all in one clock domain.

The two flags work at the granularity of whole groups. `full` rises as soon as a complete write group would no longer fit, and `empty` stays high while fewer than a complete read group are stored. A write presented while `full` is high, or a read presented while `empty` is high, is dropped. The flags are decoded from a three-state level machine, `LVL_EMPTY`, `LVL_MID` and `LVL_FULL`, which is updated on the same edge as the occupancy. Only an accepted write can move `LVL_EMPTY` to `LVL_MID`, or straight to `LVL_FULL`. From `LVL_MID`, any accepted access can move the state to `LVL_EMPTY`, back to `LVL_MID` or to `LVL_FULL`. Only an accepted read can move `LVL_FULL` to `LVL_MID`, or to `LVL_EMPTY`. In every state the machine stays where it is when no access is accepted. The read bus is registered.

Top module: `gear_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `empty` is 1, `full` is 0, `rd_data` is all zeros and the occupancy is zero.
- R2: A write stores input lane i, bits [i*WORD_W +: WORD_W], at slot (write pointer + i) mod 2^ADDR_W. A read returns slot (read pointer + j) on output lane j at the same bit position. Words therefore leave in the order they were written, with lane 0 of each group first.
- R3: `full` is 1 exactly when the occupancy exceeds 2^ADDR_W − WR_LANES.
- R4: A write while `full` is 1 is ignored: no word is stored and neither the write pointer nor the occupancy changes.
- R5: `empty` is 1 exactly when the occupancy is below RD_LANES. A read while `empty` is 1 is ignored and leaves `rd_data` unchanged.
- R6: `rd_data` changes only on the clock edge that accepts a read, and holds its value in every other cycle.
- R7: Both pointers wrap modulo 2^ADDR_W, and the word stream continues unbroken across the wrap.
- R8: When a write and a read are both accepted in one cycle, the occupancy changes by WR_LANES − RD_LANES. The read returns only words stored before that cycle.
- R9: The flags reflect the occupancy that results from an accepted access starting at the clock edge that accepts it, so the next access already sees the new flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one group of WR_LANES words |
| wr_data | input | WR_LANES*WORD_W | Write group, lane i at bits [i*WORD_W +: WORD_W] |
| rd_en | input | 1 | Read strobe for one group of RD_LANES words |
| rd_data | output | RD_LANES*WORD_W | Registered read group, lane j at bits [j*WORD_W +: WORD_W] |
| full | output | 1 | A whole write group no longer fits |
| empty | output | 1 | Fewer than RD_LANES words are stored |

## Verification
The bench builds the block with 10-bit words, a depth of 16, three lanes per write and two lanes per read. Because neither lane count divides the depth evenly, the pointers wrap at shifting offsets. Draining a full buffer leaves a single stranded word that must hold `empty` high until the next write, and a full buffer still accepts a read while the write presented in the same cycle is refused. These cases, along with long runs of random strobes compared against a word queue, cover the lane order across the wrap and both group thresholds.

// File: rtl/gear_fifo_pkg.sv
package gear_fifo_pkg;

    // Fill level classes decoded into the flags.
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_MID   = 2'd1,
        LVL_FULL  = 2'd2
    } lvl_e;

    // Map an occupancy onto a level class.
    // need: words one read consumes; room: largest occupancy that still fits a write.
    function automatic lvl_e classify(input int occ, input int need, input int room);
        if (occ < need)
            return LVL_EMPTY;
        else if (occ > room)
            return LVL_FULL;
        else
            return LVL_MID;
    endfunction

endpackage

// File: rtl/gear_fifo_ptr.sv
// Wrapping slot pointer that advances by a fixed group size.
module gear_fifo_ptr #(
    parameter int ADDR_W = 4,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= ptr + STEP_V;
    end
endmodule

// File: rtl/gear_fifo_level.sv
// Occupancy counter and the level state machine that produces the flags.
module gear_fifo_level #(
    parameter int ADDR_W   = 4,
    parameter int WR_LANES = 3,
    parameter int RD_LANES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_take,
    input  logic            rd_take,
    output logic [ADDR_W:0] occ,
    output logic            full,
    output logic            empty
);
    import gear_fifo_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;
    localparam int ROOM  = DEPTH - WR_LANES;
    localparam logic [CNT_W-1:0] ADD_V = CNT_W'(WR_LANES);
    localparam logic [CNT_W-1:0] SUB_V = CNT_W'(RD_LANES);

    lvl_e             state, state_nxt;
    logic [CNT_W-1:0] occ_nxt;

    always_comb begin
        occ_nxt = occ;
        if (wr_take)
            occ_nxt = occ_nxt + ADD_V;
        if (rd_take)
            occ_nxt = occ_nxt - SUB_V;
    end

    // Transition logic: which accepted access may leave each state.
    always_comb begin
        state_nxt = state;
        unique case (state)
            LVL_EMPTY: if (wr_take)
                state_nxt = classify(int'(occ_nxt), RD_LANES, ROOM);
            LVL_MID:   if (wr_take || rd_take)
                state_nxt = classify(int'(occ_nxt), RD_LANES, ROOM);
            LVL_FULL:  if (rd_take)
                state_nxt = classify(int'(occ_nxt), RD_LANES, ROOM);
            default:   state_nxt = LVL_EMPTY;
        endcase
    end

    // State and occupancy registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LVL_EMPTY;
            occ   <= '0;
        end else begin
            state <= state_nxt;
            occ   <= occ_nxt;
        end
    end

    // Flag outputs.
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            LVL_EMPTY: empty = 1'b1;
            LVL_MID:   ;
            LVL_FULL:  full = 1'b1;
            default:   empty = 1'b1;
        endcase
    end
endmodule

// File: rtl/gear_fifo_store.sv
// Word array with a multi-lane write port and a registered multi-lane read port.
module gear_fifo_store #(
    parameter int WORD_W   = 10,
    parameter int ADDR_W   = 4,
    parameter int WR_LANES = 3,
    parameter int RD_LANES = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_take,
    input  logic [ADDR_W-1:0]            wr_base,
    input  logic [WR_LANES*WORD_W-1:0]   wr_bus,
    input  logic                         rd_take,
    input  logic [ADDR_W-1:0]            rd_base,
    output logic [RD_LANES*WORD_W-1:0]   rd_bus
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem    [DEPTH];
    logic [WORD_W-1:0] lane_q [RD_LANES];

    // All write lanes in one process so each slot has one driver.
    always_ff @(posedge clk) begin
        if (wr_take) begin
            for (int i = 0; i < WR_LANES; i++)
                mem[wr_base + ADDR_W'(i)] <= wr_bus[i*WORD_W +: WORD_W];
        end
    end

    for (genvar j = 0; j < RD_LANES; j++) begin : g_rd_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[j] <= '0;
            else if (rd_take)
                lane_q[j] <= mem[rd_base + ADDR_W'(j)];
        end
        assign rd_bus[j*WORD_W +: WORD_W] = lane_q[j];
    end
endmodule

// File: rtl/gear_fifo.sv
// Width-converting FIFO: WR_LANES words in per write, RD_LANES words out per read.
module gear_fifo #(
    parameter int WORD_W   = 10,
    parameter int ADDR_W   = 4,
    parameter int WR_LANES = 3,
    parameter int RD_LANES = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [WR_LANES*WORD_W-1:0]  wr_data,
    input  logic                        rd_en,
    output logic [RD_LANES*WORD_W-1:0]  rd_data,
    output logic                        full,
    output logic                        empty
);
    logic              wr_take, rd_take;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [ADDR_W:0]   occ;

    assign wr_take = wr_en & ~full;
    assign rd_take = rd_en & ~empty;

    gear_fifo_ptr #(.ADDR_W(ADDR_W), .STEP(WR_LANES)) u_wr_ptr (
        .clk (clk), .rst (rst), .adv (wr_take), .ptr (wr_ptr)
    );

    gear_fifo_ptr #(.ADDR_W(ADDR_W), .STEP(RD_LANES)) u_rd_ptr (
        .clk (clk), .rst (rst), .adv (rd_take), .ptr (rd_ptr)
    );

    gear_fifo_level #(
        .ADDR_W (ADDR_W), .WR_LANES (WR_LANES), .RD_LANES (RD_LANES)
    ) u_level (
        .clk (clk), .rst (rst), .wr_take (wr_take), .rd_take (rd_take),
        .occ (occ), .full (full), .empty (empty)
    );

    gear_fifo_store #(
        .WORD_W (WORD_W), .ADDR_W (ADDR_W),
        .WR_LANES (WR_LANES), .RD_LANES (RD_LANES)
    ) u_store (
        .clk (clk), .rst (rst),
        .wr_take (wr_take), .wr_base (wr_ptr), .wr_bus (wr_data),
        .rd_take (rd_take), .rd_base (rd_ptr), .rd_bus (rd_data)
    );
endmodule

// File: rtl/gear_fifo_chk.sv
module gear_fifo_chk #(
    parameter int WORD_W   = 10,
    parameter int ADDR_W   = 4,
    parameter int WR_LANES = 3,
    parameter int RD_LANES = 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic                        full,
    input logic                        empty,
    input logic [RD_LANES*WORD_W-1:0]  rd_data,
    input logic [ADDR_W-1:0]           wr_ptr,
    input logic [ADDR_W-1:0]           rd_ptr,
    input logic [ADDR_W:0]             occ
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

    p_reset_level_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (empty && !full && occ == '0));

    p_wr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full) |=> wr_ptr == $past(wr_ptr) + ADDR_W'(WR_LANES));

    p_rd_step_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty) |=> rd_ptr == $past(rd_ptr) + ADDR_W'(RD_LANES));

    p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH_V);

    p_no_write_when_full_r4: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(wr_ptr));

    p_hold_when_empty_r5: assert property (@(posedge clk) disable iff (rst)
        empty |=> $stable(rd_data));

    p_hold_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_occ_matches_ptrs_r8: assert property (@(posedge clk) disable iff (rst)
        occ[ADDR_W-1:0] == ADDR_W'(wr_ptr - rd_ptr));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
endmodule

bind gear_fifo gear_fifo_chk #(
    .WORD_W (WORD_W), .ADDR_W (ADDR_W),
    .WR_LANES (WR_LANES), .RD_LANES (RD_LANES)
) u_chk (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
    .full (full), .empty (empty), .rd_data (rd_data),
    .wr_ptr (wr_ptr), .rd_ptr (rd_ptr), .occ (occ)
);

// File: tb/gear_fifo_test.sv
`timescale 1ns/1ps
module gear_fifo_test;
    localparam int WW = 10;
    localparam int AW = 4;
    localparam int WL = 3;
    localparam int RL = 2;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [WL*WW-1:0] wr_data = '0;
    logic [RL*WW-1:0] rd_data;
    logic full, empty;

    int total = 0;
    int bad = 0;
    logic [WW-1:0] q[$];
    logic [RL*WW-1:0] last = '0;
    int seq = 1;

    always #10 clk = ~clk;

    gear_fifo #(.WORD_W(WW), .ADDR_W(AW), .WR_LANES(WL), .RD_LANES(RL)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty)
    );

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [WL*WW-1:0] next_group();
        logic [WL*WW-1:0] g;
        for (int i = 0; i < WL; i++) begin
            g[i*WW +: WW] = WW'(seq);
            seq++;
        end
        return g;
    endfunction

    // One access cycle, started and finished at a falling edge.
    task automatic step(input bit w, input bit r);
        bit fm, em;
        logic [WL*WW-1:0] g;
        logic [RL*WW-1:0] exp;
        g  = next_group();
        fm = q.size() > DEPTH - WL;
        em = q.size() < RL;
        check(full === fm, "R3/R9 full flag", 32'(full), 32'(fm));
        check(empty === em, "R5/R9 empty flag", 32'(empty), 32'(em));
        wr_en = w; rd_en = r; wr_data = g;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (r && !em) begin
            for (int j = 0; j < RL; j++) exp[j*WW +: WW] = q.pop_front();
            check(rd_data === exp, "R2 lane order", 32'(rd_data), 32'(exp));
        end else begin
            check(rd_data === last, "R5/R6 output hold", 32'(rd_data), 32'(last));
        end
        if (w && !fm)
            for (int i = 0; i < WL; i++) q.push_back(g[i*WW +: WW]);
        last = rd_data;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(empty === 1'b1, "R1 empty in reset", 32'(empty), 32'd1);
        check(full === 1'b0, "R1 full in reset", 32'(full), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data === '0, "R1 read bus after reset", 32'(rd_data), 32'd0);
        check(empty === 1'b1, "R1 empty after reset", 32'(empty), 32'd1);
        q.delete();
        last = '0;
    endtask

    // R3/R4: five groups fill to 15 words; the sixth is refused.
    task automatic t_fill();
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        check(full === 1'b1, "R3 full after five groups", 32'(full), 32'd1);
        step(1'b1, 1'b0);
        check(q.size() == 15, "R4 refused write left count", 32'(q.size()), 32'd15);
    endtask

    // R4/R8: read and write together while full: only the read is taken.
    task automatic t_full_both();
        step(1'b1, 1'b1);
    endtask

    // R5: drain until a lone word remains, then read while empty.
    task automatic t_drain();
        while (q.size() >= RL) step(1'b0, 1'b1);
        check(empty === 1'b1, "R5 stranded word keeps empty", 32'(empty), 32'd1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
    endtask

    // R8: simultaneous accepted write and read.
    task automatic t_both();
        step(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1);
    endtask

    // R7: random strobes push both pointers around the ring many times.
    task automatic t_random();
        for (int k = 0; k < 400; k++) step(1'($urandom % 2), 1'($urandom % 2));
        while (q.size() >= RL) step(1'b0, 1'b1);
        check(empty === 1'b1, "R7 drained after wraps", 32'(empty), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_full_both();
        t_drain();
        t_both();
        t_random();
        t_reset();
        t_both();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule